// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block closes the current-regulation loop of one bridge of a motor driver. While the bridge is active, the low-side switch conducts and the winding current rises. A digitised comparator flag reports when the sensed current has passed the reference. The block then raises a chop request. That request tells the bridge control logic to turn the low side off and to let the current recirculate through the upper path (slow decay) for a fixed number of clock cycles. When that interval ends, the request drops.

The low side comes back on only after the bridge control logic has inserted its deadtime. The block therefore waits for an acknowledge before it treats a new on phase as started. As a result, the real off interval is the programmed count plus the deadtime that the bridge logic spends.

Every new on phase opens with a blanking window. During that window the comparator is ignored, so the reverse-recovery spike at low-side turn-on cannot end the phase. A minimum on time is also enforced. A trip seen after blanking but before that minimum is held, and it takes effect at the minimum. The blanking, minimum-on and off lengths are register inputs counted in clock cycles. A phase code is exposed for observation.

Top module: `offtime_chopper`

## Requirements
- R1: After reset the phase output is 0 (idle) and chopReq is 0.
- R2: An on phase starts only at a clock edge where the block is in idle, bridgeEn is 1 and lowOnAck is 1. The first on cycle shows phase 1 (blanked), or phase 2 (on) when blankLen is 0. lowOnAck has no effect in any other phase.
- R3: The first blankLen cycles of an on phase show phase 1. A senseTrip high during those cycles is ignored, even as a single-cycle pulse.
- R4: Let q be the first on-phase cycle index (0-based) at or after blankLen in which senseTrip is high. Then the on phase lasts max(q+1, minOnLen) cycles, and chopReq rises at the edge that ends it.
- R5: A senseTrip pulse that arrives after blanking but before the minimum on time is remembered. It ends the on phase after exactly minOnLen cycles, even though senseTrip has returned low.
- R6: chopReq stays high, with phase 3 (off), for exactly max(offLen, 1) cycles. The block then returns to phase 0 with chopReq low.
- R7: After the off interval the block stays idle, with no chop request, until lowOnAck is sampled high. The gap from chopReq falling to the next on phase is one cycle plus the number of extra cycles before the acknowledge.
- R8: bridgeEn sampled low forces phase 0 and chopReq 0 at the next edge, from any phase. It also discards a remembered trip. While bridgeEn is low, lowOnAck is ignored.
- R9: chopReq is 1 exactly when phase is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridgeEn | input | 1 | Bridge active; low returns the block to idle |
| lowOnAck | input | 1 | Bridge logic reports the low-side switch is now on (after its deadtime) |
| senseTrip | input | 1 | Digitised comparator: sensed current above reference |
| blankLen | input | CNT_W | Blanking window length in cycles |
| minOnLen | input | CNT_W | Minimum on-phase length in cycles |
| offLen | input | CNT_W | Off interval length in cycles (0 acts as 1) |
| chopReq | output | 1 | Request to turn the low side off (recirculation phase) |
| phase | output | 2 | 0 idle, 1 on blanked, 2 on, 3 off timing |

## Verification
The bound checker watches every cycle for the following:
- a chop request rises only out of the on phase, and never before both the minimum on time and the end of blanking;
- an on phase never begins without an acknowledge in idle;
- disabling the bridge always lands in idle;
- each completed off interval has its programmed length.

Only the bench scenarios can show the exact on-phase length for a given trip pattern. They also show that trip pulses inside blanking leave no trace, that a remembered trip is discarded by a disable, and that the idle gap tracks the acknowledge latency. For these, the bench sweeps blanking, minimum-on and off lengths against the trip position and the acknowledge delay.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BLANK = 2'd1,
    PH_ON    = 2'd2,
    PH_OFF   = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic startOn;
    logic runOn;
    logic startOff;
    logic runOff;
  } ctrl_strobes_t;

  // compare results from datapath to control
  typedef struct packed {
    logic blankZero;
    logic blankLast;
    logic minOnMet;
    logic offLast;
  } dp_flags_t;

  localparam int NUM_TIMERS = 2;
  localparam int TMR_ON     = 0;
  localparam int TMR_OFF    = 1;

endpackage

// File: rtl/chop_cycle_counter.sv
module chop_cycle_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             run,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr || start) begin
      count <= '0;
    end else if (run && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/offtime_chopper_dp.sv
module offtime_chopper_dp
  import chop_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_strobes_t    strb,
  input  logic [CNT_W-1:0] blankLen,
  input  logic [CNT_W-1:0] minOnLen,
  input  logic [CNT_W-1:0] offLen,
  output dp_flags_t        flags
);
  localparam int EXT_W = CNT_W + 1;

  logic [NUM_TIMERS-1:0] tStart;
  logic [NUM_TIMERS-1:0] tRun;
  logic [CNT_W-1:0]      tCount [NUM_TIMERS];

  assign tStart[TMR_ON]  = strb.startOn;
  assign tRun[TMR_ON]    = strb.runOn;
  assign tStart[TMR_OFF] = strb.startOff;
  assign tRun[TMR_OFF]   = strb.runOff;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
    chop_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (strb.clearAll),
      .start (tStart[i]),
      .run   (tRun[i]),
      .count (tCount[i])
    );
  end

  // cycles elapsed including the current one
  logic [EXT_W-1:0] onElapsed;
  logic [EXT_W-1:0] offElapsed;
  assign onElapsed  = {1'b0, tCount[TMR_ON]}  + EXT_W'(1);
  assign offElapsed = {1'b0, tCount[TMR_OFF]} + EXT_W'(1);

  always_comb begin
    flags.blankZero = (blankLen == '0);
    flags.blankLast = (onElapsed  >= {1'b0, blankLen});
    flags.minOnMet  = (onElapsed  >= {1'b0, minOnLen});
    flags.offLast   = (offElapsed >= {1'b0, offLen});
  end
endmodule

// File: rtl/offtime_chopper_fsm.sv
module offtime_chopper_fsm
  import chop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bridgeEn,
  input  logic          lowOnAck,
  input  logic          senseTrip,
  input  dp_flags_t     flags,
  output ctrl_strobes_t strb,
  output phase_e        phase
);
  phase_e state, stateNxt;
  logic   pending, pendingNxt;
  logic   tripHit;

  assign tripHit = senseTrip || pending;

  always_comb begin
    stateNxt   = state;
    pendingNxt = pending;
    strb       = '0;
    if (!bridgeEn) begin
      stateNxt      = PH_IDLE;
      pendingNxt    = 1'b0;
      strb.clearAll = 1'b1;
    end else begin
      case (state)
        PH_IDLE: begin
          if (lowOnAck) begin
            strb.startOn = 1'b1;
            pendingNxt   = 1'b0;
            stateNxt     = flags.blankZero ? PH_ON : PH_BLANK;
          end
        end
        PH_BLANK: begin
          strb.runOn = 1'b1;
          if (flags.blankLast) stateNxt = PH_ON;
        end
        PH_ON: begin
          strb.runOn = 1'b1;
          if (tripHit && flags.minOnMet) begin
            stateNxt      = PH_OFF;
            pendingNxt    = 1'b0;
            strb.startOff = 1'b1;
          end else if (senseTrip) begin
            pendingNxt = 1'b1;
          end
        end
        PH_OFF: begin
          strb.runOff = 1'b1;
          if (flags.offLast) stateNxt = PH_IDLE;
        end
        default: stateNxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      pending <= 1'b0;
    end else begin
      state   <= stateNxt;
      pending <= pendingNxt;
    end
  end

  assign phase = state;
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bridgeEn,
  input  logic             lowOnAck,
  input  logic             senseTrip,
  input  logic [CNT_W-1:0] blankLen,
  input  logic [CNT_W-1:0] minOnLen,
  input  logic [CNT_W-1:0] offLen,
  output logic             chopReq,
  output logic [1:0]       phase
);
  ctrl_strobes_t strb;
  dp_flags_t     flags;
  phase_e        phaseInt;

  offtime_chopper_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bridgeEn  (bridgeEn),
    .lowOnAck  (lowOnAck),
    .senseTrip (senseTrip),
    .flags     (flags),
    .strb      (strb),
    .phase     (phaseInt)
  );

  offtime_chopper_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .blankLen (blankLen),
    .minOnLen (minOnLen),
    .offLen   (offLen),
    .flags    (flags)
  );

  assign phase   = phaseInt;
  assign chopReq = (phaseInt == PH_OFF);
endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bridgeEn,
  input logic             lowOnAck,
  input logic [CNT_W-1:0] blankLen,
  input logic [CNT_W-1:0] minOnLen,
  input logic [CNT_W-1:0] offLen,
  input logic             chopReq,
  input logic [1:0]       phase
);
  localparam int RUN_W = CNT_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic inOn;
  assign inOn = (phase == 2'd1) || (phase == 2'd2);

  logic [RUN_W-1:0] onRun, offRun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onRun  <= '0;
      offRun <= '0;
    end else begin
      onRun  <= inOn ? ((onRun == RUN_MAX) ? onRun : onRun + 1'b1) : '0;
      offRun <= (phase == 2'd3) ? ((offRun == RUN_MAX) ? offRun : offRun + 1'b1) : '0;
    end
  end

  logic [RUN_W-1:0] offWant;
  assign offWant = (offLen == '0) ? RUN_W'(1) : {1'b0, offLen};

  // R4
  chop_from_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chopReq) |-> $past(phase) == 2'd2);

  // R5
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chopReq) |-> onRun >= {1'b0, $past(minOnLen)});

  // R3
  blank_no_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chopReq) |-> onRun > {1'b0, $past(blankLen)});

  // R2
  on_entry_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inOn && $past(!inOn)) |-> ($past(phase) == 2'd0 && $past(lowOnAck) && $past(bridgeEn)));

  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bridgeEn |=> (phase == 2'd0 && !chopReq));

  // R6
  off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(chopReq) && $past(bridgeEn)) |-> offRun == $past(offWant));

  // R9
  chop_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chopReq == (phase == 2'd3));
endmodule

bind offtime_chopper offtime_chopper_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bridgeEn (bridgeEn),
  .lowOnAck (lowOnAck),
  .blankLen (blankLen),
  .minOnLen (minOnLen),
  .offLen   (offLen),
  .chopReq  (chopReq),
  .phase    (phase)
);

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int MAX_WAIT = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bridgeEn = 1'b0;
  logic lowOnAck = 1'b0;
  logic senseTrip = 1'b0;
  logic [W-1:0] blankLen = '0;
  logic [W-1:0] minOnLen = '0;
  logic [W-1:0] offLen = '0;
  logic chopReq;
  logic [1:0] phase;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  offtime_chopper #(.CNT_W(W)) u_offtime_chopper (
    .clk(clk), .rst_n(rst_n), .bridgeEn(bridgeEn), .lowOnAck(lowOnAck),
    .senseTrip(senseTrip), .blankLen(blankLen), .minOnLen(minOnLen),
    .offLen(offLen), .chopReq(chopReq), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tripAt(int k, int pulseAt, int levelAt);
    return (k == pulseAt) || (levelAt >= 0 && k >= levelAt);
  endfunction

  // expected on-phase length from the requirements
  function automatic int expOnLen(int blank, int minOn, int pulseAt, int levelAt);
    for (int k = 0; k < MAX_WAIT; k++) begin
      if (k >= blank && tripAt(k, pulseAt, levelAt))
        return (k + 1 > minOn) ? k + 1 : minOn;
    end
    return MAX_WAIT;
  endfunction

  // starts in idle at a negedge; runs one on/off cycle and ends in idle
  task automatic runChop(input int blank, input int minOn, input int offL,
                         input int pulseAt, input int levelAt, input int gap,
                         input bit holdAck);
    int idleSeen = 0;
    int blankSeen = 0;
    int wrongPh = 0;
    int k = 0;
    int n = 0;
    int expOff;
    blankLen = W'(blank);
    minOnLen = W'(minOn);
    offLen   = W'(offL);
    senseTrip = 1'b0;
    lowOnAck = holdAck;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (phase == 2'd0 && !chopReq) idleSeen++;
    end
    // R7: idle holds with no acknowledge
    check("R7 idle until ack", idleSeen, gap);
    lowOnAck = 1'b1;
    @(negedge clk);
    lowOnAck = holdAck;
    // R2: entry phase code
    check("R2 on entry phase", int'(phase), (blank == 0) ? 2 : 1);
    while ((phase == 2'd1 || phase == 2'd2) && k < MAX_WAIT) begin
      if (phase == 2'd1) blankSeen++;
      if (int'(phase) != ((k < blank) ? 1 : 2)) wrongPh++;
      senseTrip = tripAt(k, pulseAt, levelAt);
      @(negedge clk);
      k++;
    end
    check("R3 blanked cycles", blankSeen, blank);
    check("R3 phase sequence errors", wrongPh, 0);
    check("R4 R5 on length", k, expOnLen(blank, minOn, pulseAt, levelAt));
    check("R9 chopReq in off", int'(chopReq), 1);
    senseTrip = 1'b0;
    while (phase == 2'd3 && n < MAX_WAIT) begin
      if (!chopReq) wrongPh++;
      @(negedge clk);
      n++;
    end
    expOff = (offL == 0) ? 1 : offL;
    check("R6 off length", n, expOff);
    check("R6 R9 back to idle", {30'd0, phase} + (chopReq ? 8 : 0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset phase", int'(phase), 0);
    check("R1 reset chopReq", int'(chopReq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(phase), 0);
    bridgeEn = 1'b1;
    // R2: no ack, stays idle
    repeat (4) @(negedge clk);
    check("R2 no ack stays idle", int'(phase), 0);

    // sweep: blanking x min-on x trip position x off length x ack delay
    foreach (blankSweep[bi]) ;
    for (int b = 0; b < 3; b++)
      for (int m = 0; m < 3; m++)
        for (int t = 0; t < 8; t++)
          for (int o = 0; o < 3; o++)
            for (int g = 0; g < 2; g++)
              runChop(blankSweep[b], minSweep[m], offSweep[o], -1, t, 2 * g, 1'b0);

    // R2: ack held high through on and off phases has no effect there
    runChop(2, 3, 4, -1, 5, 0, 1'b1);
    runChop(0, 0, 2, -1, 0, 0, 1'b1);
    lowOnAck = 1'b0;

    // R3: single pulse inside blanking ignored, later level trip ends phase
    runChop(4, 0, 2, 1, 9, 1, 1'b0);
    runChop(4, 0, 2, 3, 7, 0, 1'b0);
    // R5: pulse after blanking, before min-on, is remembered
    runChop(1, 6, 2, 2, -1, 0, 1'b0);
    runChop(0, 9, 3, 0, -1, 0, 1'b0);

    // R8: disable with a remembered trip, then re-enable
    blankLen = W'(1); minOnLen = W'(8); offLen = W'(3);
    lowOnAck = 1'b1;
    @(negedge clk);
    lowOnAck = 1'b0;
    for (int k = 0; k < 5; k++) begin
      senseTrip = (k == 2);
      @(negedge clk);
    end
    senseTrip = 1'b0;
    bridgeEn = 1'b0;
    @(negedge clk);
    check("R8 disable forces idle", int'(phase), 0);
    check("R8 disable no chop", int'(chopReq), 0);
    lowOnAck = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 ack ignored while disabled", int'(phase), 0);
    bridgeEn = 1'b1;
    @(negedge clk);
    lowOnAck = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 remembered trip discarded", int'(phase), 2);
    check("R8 no chop without new trip", int'(chopReq), 0);
    senseTrip = 1'b1;
    @(negedge clk);
    senseTrip = 1'b0;
    check("R4 chop after late trip", int'(chopReq), 1);
    // R8: disable in the middle of the off interval
    bridgeEn = 1'b0;
    @(negedge clk);
    check("R8 disable during off", int'(phase), 0);
    check("R8 R9 chop dropped", int'(chopReq), 0);
    bridgeEn = 1'b1;
    @(negedge clk);

    // R7: long acknowledge delay
    runChop(2, 2, 5, -1, 3, 7, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  int blankSweep [3] = '{0, 1, 3};
  int minSweep   [3] = '{0, 2, 5};
  int offSweep   [3] = '{0, 1, 4};
endmodule